// File: doc/BRIEF.md
# CAN Error Counters with Error Logging

This block holds the transmit and receive error counters of a CAN controller, together with an error-logging counter that software reads to see how many protocol errors happened since its last read. The protocol engine drives it with one-cycle strobes: transmit error, receive error, successful transmit and successful receive. A restricted-operation mode input stops protocol errors from moving the two error counters, while the logging counter keeps counting them. All three counters are presented on one read-only 32-bit status word, and a one-cycle pulse reports that a logged error was lost because the logging counter was already full.

The receive side keeps an internal count wider than its 7-bit status field. A two-state machine (`RX_ACTIVE`, `RX_PASSIVE`) tracks the receive-passive condition. It takes the `RX_ACTIVE -> RX_PASSIVE` transition when the next count reaches 128 or more, and the `RX_PASSIVE -> RX_ACTIVE` transition when the count falls back below 128. The logging counter has its own two-state machine (`LOG_COUNTING`, `LOG_FULL`). It takes the `LOG_COUNTING -> LOG_FULL` transition when an increment lands on 0xFF. It takes the `LOG_FULL -> LOG_COUNTING` transition on a read-clear. While in `LOG_FULL`, every further qualifying error raises the overflow pulse.

A read of the status word is signalled by a read strobe qualified with an address match, and it clears the logging counter. All state is updated on the rising clock edge, and each update is visible on the outputs in the cycle after the strobe.

Top module: `can_errcnt_log`

## Requirements
- R1: The status word carries the logging counter in bits 23:16, the receive-passive flag in bit 15, the receive field in bits 14:8 and the transmit counter in bits 7:0. Bits 31:24 always read 0, and the whole word is 0x00000000 after reset with `log_ovf_o` low.
- R2: Each `tx_err_i` or `rx_err_i` strobe increments the logging counter by one, whether or not restricted mode is set.
- R3: The logging counter stops at 0xFF. A qualifying error while it is at 0xFF leaves it at 0xFF and drives `log_ovf_o` high for exactly the following cycle. `log_ovf_o` is otherwise low.
- R4: A cycle with `rd_stb_i` and `rd_addr_hit_i` both high clears the logging counter to 0. `rd_stb_i` without `rd_addr_hit_i` has no effect.
- R5: While `restrict_i` is high, error strobes leave the transmit and receive counters unchanged, and a success strobe in the same cycle still applies. The logging counter still increments and can still raise `log_ovf_o`.
- R6: A read-clear and a qualifying error in the same cycle leave the logging counter at 1 and raise no overflow pulse, even if the counter was at 0xFF.
- R7: Outside restricted mode, `tx_err_i` adds 8 to the transmit counter, saturating at 255. `tx_ok_i` subtracts 1 with a floor of 0. When both arrive in the same cycle, the error takes priority and the success is dropped.
- R8: Outside restricted mode, `rx_err_i` adds 1 to the internal receive count, saturating at 255. `rx_ok_i` subtracts 1 with a floor of 0. When both arrive in the same cycle, the error takes priority.
- R9: The receive-passive flag is 1 exactly when the internal receive count is 128 or more, and the receive field then reads 127. Below 128, the field reads the count and the flag is 0.
- R10: Every counter change caused by strobes sampled at a clock edge appears on `status_o` right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit protocol error strobe |
| rx_err_i | input | 1 | Receive protocol error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| restrict_i | input | 1 | Restricted-operation mode |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_hit_i | input | 1 | Read address selects the status word |
| status_o | output | 32 | Packed counter status word |
| log_ovf_o | output | 1 | One-cycle logging overflow pulse |

## Verification
The transmit and receive counters are driven by long runs of a single strobe. These runs show saturation at 255 separately from the floor at 0, and the passive-threshold crossing in each direction separately from the 127 clamp on the field. The logging counter is filled to 0xFF and pushed one event past it. This separates saturation from wrapping, and it shows that the overflow pulse lasts one cycle. It is then hit with a read-clear alone, a read without an address match, and a read-clear coinciding with an error while full.

Restricted mode is tried with each error strobe, with and without a success strobe in the same cycle. This tells counter freezing apart from logging. A long pseudo-random sweep then mixes all strobes, the mode and reads, against an arithmetic model, to catch priority and ordering errors that the directed runs do not reach.

// File: rtl/can_errcnt_pkg.sv
package can_errcnt_pkg;

    localparam int STATUS_W = 32;
    localparam int LOG_LSB  = 16;
    localparam int RXP_BIT  = 15;
    localparam int REC_LSB  = 8;
    localparam int TEC_LSB  = 0;

    typedef enum logic {
        RX_ACTIVE,
        RX_PASSIVE
    } rx_state_e;

    typedef enum logic {
        LOG_COUNTING,
        LOG_FULL
    } log_state_e;

endpackage

// File: rtl/can_errcnt_tx.sv
module can_errcnt_tx #(
    parameter int TEC_W = 8,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             ok_i,
    input  logic             restrict_i,
    output logic [TEC_W-1:0] cnt_o
);
    localparam logic [TEC_W:0] STEP_V = (TEC_W+1)'(STEP);

    logic [TEC_W-1:0] cnt_q, cnt_d;
    logic [TEC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + STEP_V;
        cnt_d = cnt_q;
        if (err_i && !restrict_i) begin
            cnt_d = sum[TEC_W] ? '1 : sum[TEC_W-1:0];
        end else if (ok_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/can_errcnt_rx.sv
module can_errcnt_rx
    import can_errcnt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int FIELD_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_i,
    input  logic               ok_i,
    input  logic               restrict_i,
    output logic [FIELD_W-1:0] field_o,
    output logic               passive_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    rx_state_e        st_q, st_d;

    // next count and next state
    always_comb begin
        cnt_d = cnt_q;
        if (err_i && !restrict_i) begin
            if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        end else if (ok_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
        st_d = st_q;
        unique case (st_q)
            RX_ACTIVE:  if (cnt_d[CNT_W-1:FIELD_W] != '0) st_d = RX_PASSIVE;
            RX_PASSIVE: if (cnt_d[CNT_W-1:FIELD_W] == '0) st_d = RX_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_ACTIVE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            RX_ACTIVE: begin
                field_o   = cnt_q[FIELD_W-1:0];
                passive_o = 1'b0;
            end
            RX_PASSIVE: begin
                field_o   = '1;
                passive_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/can_errcnt_logger.sv
module can_errcnt_logger
    import can_errcnt_pkg::*;
#(
    parameter int LOG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual_i,
    input  logic             clr_i,
    output logic [LOG_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [LOG_W-1:0] cnt_q, cnt_d, cnt_inc;
    log_state_e       st_q, st_d;
    logic             ovf_q, ovf_d;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        cnt_d   = cnt_q;
        st_d    = st_q;
        ovf_d   = 1'b0;
        if (clr_i) begin
            cnt_d = LOG_W'(qual_i);
            st_d  = LOG_COUNTING;
        end else if (qual_i) begin
            unique case (st_q)
                LOG_COUNTING: begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == '1) st_d = LOG_FULL;
                end
                LOG_FULL: ovf_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LOG_COUNTING;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;
endmodule

// File: rtl/can_errcnt_log.sv
module can_errcnt_log
    import can_errcnt_pkg::*;
#(
    parameter int TEC_W    = 8,
    parameter int TX_STEP  = 8,
    parameter int RX_CNT_W = 8,
    parameter int REC_W    = 7,
    parameter int LOG_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_err_i,
    input  logic                rx_err_i,
    input  logic                tx_ok_i,
    input  logic                rx_ok_i,
    input  logic                restrict_i,
    input  logic                rd_stb_i,
    input  logic                rd_addr_hit_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                log_ovf_o
);
    logic [TEC_W-1:0] tec;
    logic [REC_W-1:0] rec;
    logic             rx_passive;
    logic [LOG_W-1:0] log_cnt;
    logic             qual, clr;

    assign qual = tx_err_i | rx_err_i;
    assign clr  = rd_stb_i & rd_addr_hit_i;

    can_errcnt_tx #(.TEC_W(TEC_W), .STEP(TX_STEP)) u_tx (
        .clk(clk), .rst_n(rst_n), .err_i(tx_err_i), .ok_i(tx_ok_i),
        .restrict_i(restrict_i), .cnt_o(tec)
    );

    can_errcnt_rx #(.CNT_W(RX_CNT_W), .FIELD_W(REC_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .err_i(rx_err_i), .ok_i(rx_ok_i),
        .restrict_i(restrict_i), .field_o(rec), .passive_o(rx_passive)
    );

    can_errcnt_logger #(.LOG_W(LOG_W)) u_log (
        .clk(clk), .rst_n(rst_n), .qual_i(qual), .clr_i(clr),
        .cnt_o(log_cnt), .ovf_o(log_ovf_o)
    );

    always_comb begin
        status_o                     = '0;
        status_o[LOG_LSB +: LOG_W]   = log_cnt;
        status_o[RXP_BIT]            = rx_passive;
        status_o[REC_LSB +: REC_W]   = rec;
        status_o[TEC_LSB +: TEC_W]   = tec;
    end
endmodule

// File: rtl/can_errcnt_log_chk.sv
module can_errcnt_log_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_err_i,
    input logic        rx_err_i,
    input logic        tx_ok_i,
    input logic        rx_ok_i,
    input logic        restrict_i,
    input logic        rd_stb_i,
    input logic        rd_addr_hit_i,
    input logic [31:0] status_o,
    input logic        log_ovf_o
);
    logic [7:0] logf, tecf;
    logic [6:0] recf;
    logic       clr, qual;

    assign logf = status_o[23:16];
    assign recf = status_o[14:8];
    assign tecf = status_o[7:0];
    assign clr  = rd_stb_i && rd_addr_hit_i;
    assign qual = tx_err_i || rx_err_i;

    a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[31:24] == 8'h00);

    a_r2_log_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && qual && logf != 8'hFF) |=> logf == $past(logf) + 8'd1);

    a_r3_log_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && qual && logf == 8'hFF) |=> (logf == 8'hFF) && log_ovf_o);

    a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        log_ovf_o |-> $past(logf == 8'hFF && qual && !clr));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !qual) |=> logf == 8'h00);

    a_r5_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (restrict_i && tx_err_i) |=> tecf <= $past(tecf));

    a_r6_clear_and_err: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && qual) |=> (logf == 8'h01) && !log_ovf_o);

    a_r7_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_i && !restrict_i) |=>
            tecf == (($past(tecf) > 8'd247) ? 8'hFF : $past(tecf) + 8'd8));

    a_r9_passive_field: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[15] |-> recf == 7'h7F);
endmodule

bind can_errcnt_log can_errcnt_log_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
    .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .restrict_i(restrict_i),
    .rd_stb_i(rd_stb_i), .rd_addr_hit_i(rd_addr_hit_i),
    .status_o(status_o), .log_ovf_o(log_ovf_o)
);

// File: tb/can_errcnt_log_bench.sv
module can_errcnt_log_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0;
    logic        restrict_i = 0, rd_stb_i = 0, rd_addr_hit_i = 0;
    logic [31:0] status_o;
    logic        log_ovf_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_tx = 0, m_rx = 0, m_log = 0;
    bit m_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_errcnt_log u_can_errcnt_log (
        .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
        .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .restrict_i(restrict_i),
        .rd_stb_i(rd_stb_i), .rd_addr_hit_i(rd_addr_hit_i),
        .status_o(status_o), .log_ovf_o(log_ovf_o)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s        = '0;
        s[23:16] = 8'(m_log);
        s[15]    = (m_rx >= 128);
        s[14:8]  = (m_rx >= 128) ? 7'h7F : 7'(m_rx);
        s[7:0]   = 8'(m_tx);
        return s;
    endfunction

    task automatic check(input string tag);
        logic [31:0] e;
        e = exp_status();
        total++;
        if (status_o !== e || log_ovf_o !== m_ovf) begin
            bad++;
            $display("FAIL %s: status=%h ovf=%b expected status=%h ovf=%b",
                     tag, status_o, log_ovf_o, e, m_ovf);
        end
    endtask

    // drive one cycle after a falling edge, update model, check at next falling edge
    task automatic cyc(input bit te, input bit re, input bit tok, input bit rok,
                       input bit rs, input bit rd, input bit hit, input string tag);
        bit q, c;
        tx_err_i = te; rx_err_i = re; tx_ok_i = tok; rx_ok_i = rok;
        restrict_i = rs; rd_stb_i = rd; rd_addr_hit_i = hit;
        q = te | re;
        c = rd & hit;
        m_ovf = 0;
        if (c) m_log = q ? 1 : 0;
        else if (q) begin
            if (m_log == 255) m_ovf = 1;
            else m_log++;
        end
        if (te && !rs) m_tx = (m_tx + 8 > 255) ? 255 : m_tx + 8;
        else if (tok && m_tx > 0) m_tx--;
        if (re && !rs) m_rx = (m_rx == 255) ? 255 : m_rx + 1;
        else if (rok && m_rx > 0) m_rx--;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R7: saturate at 255, floor at 0, error over success
        for (int i = 0; i < 40; i++) cyc(1,0,0,0,0,0,0, "R7 tx err run");
        for (int i = 0; i < 270; i++) cyc(0,0,1,0,0,0,0, "R7 tx ok run");
        cyc(1,0,1,0,0,0,0, "R7 err beats ok");

        // R8/R9: cross passive threshold both ways, saturate internal count
        for (int i = 0; i < 140; i++) cyc(0,1,0,0,0,0,0, "R9 rx rise");
        for (int i = 0; i < 30; i++)  cyc(0,0,0,1,0,0,0, "R9 rx fall");
        for (int i = 0; i < 160; i++) cyc(0,1,0,0,0,0,0, "R8 rx saturate");
        cyc(0,1,0,1,0,0,0, "R8 err beats ok");
        for (int i = 0; i < 270; i++) cyc(0,0,0,1,0,0,0, "R8 rx floor");

        // R4: read without address match ignored, then clear
        cyc(0,0,0,0,0,1,0, "R4 read no hit");
        cyc(0,0,0,0,0,0,1, "R4 hit no read");
        cyc(0,0,0,0,0,1,1, "R4 read clear");

        // R5: restricted mode freezes counters but logs
        cyc(1,0,0,0,0,0,0, "R5 setup tx");
        cyc(0,1,0,0,0,0,0, "R5 setup rx");
        cyc(1,0,0,0,1,0,0, "R5 tx err restricted");
        cyc(0,1,0,0,1,0,0, "R5 rx err restricted");
        cyc(1,0,1,0,1,0,0, "R5 tx ok applies");
        cyc(0,1,0,1,1,0,0, "R5 rx ok applies");

        // R2/R3: fill logger, saturate, overflow pulse lasts one cycle
        cyc(0,0,0,0,0,1,1, "R4 clear before fill");
        for (int i = 0; i < 255; i++) cyc(i % 2, (i + 1) % 2, 1, 1, 0,0,0, "R2 fill");
        cyc(0,1,0,0,0,0,0, "R3 overflow event");
        cyc(0,0,0,0,0,0,0, "R3 pulse ends");
        cyc(1,0,0,0,1,0,0, "R5 overflow in restricted");
        cyc(0,0,0,0,0,0,0, "R3 hold full");

        // R6: clear and error in same cycle while full
        cyc(0,1,0,0,0,1,1, "R6 clear with error");
        cyc(1,0,0,0,0,0,0, "R2 count after clear");

        // R10: mixed pseudo-random sweep
        lf = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            bit te, re;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            te = lf[0] & lf[3];
            re = lf[1] & ~te;
            cyc(te, re, lf[2], lf[4], lf[5] & lf[6] & lf[7],
                lf[8] & lf[9] & lf[11], lf[10] | lf[12], "R10 sweep");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule